// File: doc/BRIEF.md
# Stop-Clock Power State Controller

This block governs the idle power states of one processor core. It tracks five states: running, halted, halted while a cache snoop is serviced, stopped on request of the external stop-clock input, and stopped while a snoop is serviced. A halt is entered when the core requests it and the halt bus cycle has been acknowledged. A halt leaves for running when one of seven break-event lines fires. The stop-clock input can be asserted from running or from halted. On release it returns to the state it left.

When the core's present clock ratio is above the minimum, a halt lowers power further. The ratio drops to the minimum first and the voltage code drops second. Each step holds for a programmable settle count. On the way out the order is reversed: the voltage code that was saved at entry is restored first, then the saved ratio. Break events that arrive while either sequence runs are held, and the core only runs again once the whole exit sequence is done. At the minimum ratio a halt is a plain halt, with no change of operating point.

Top module: `stopclk_pwr_ctrl`

## Requirements
- R1: After reset `pstate` is 0 (running), `run_en` is 1, `low_power` is 0, and `vid_code`/`ratio_code` equal `op_vid`/`op_ratio`.
- R2: In running, with `clk_stop_n` high, `halt_req` and `halt_ack` both high at a clock edge give `pstate` 1 (halted) after that edge. `halt_req` without `halt_ack` has no effect.
- R3: In halted with no operating-point sequence, any bit of `brk_evt` (bit 0 init, 1 bus init, 2 maskable interrupt, 3 non-maskable interrupt, 4 system-management interrupt, 5 reset, 6 bus interrupt message) gives `pstate` 0 after the next edge.
- R4: `clk_stop_n` low moves running or halted to `pstate` 3 (stop granted). When it goes high again the state returns to where it came from: 0 or 1.
- R5: `snoop_req` moves halted to `pstate` 2 and stop-granted to `pstate` 4. `snoop_done` returns them to 1 and 3 respectively.
- R6: In halted, a low `clk_stop_n` wins over `snoop_req` and break events. Break events seen outside running are held. They do not leave stop-granted, but they take effect once halted is reached again.
- R7: Halting with `op_ratio` > RATIO_MIN sets `low_power`, sets `ratio_code` to RATIO_MIN and keeps `vid_code`, all for `settle_cycles`+1 cycles. After that `vid_code` becomes VID_LOW.
- R8: Halting with `op_ratio` equal to RATIO_MIN leaves `vid_code`, `ratio_code` and `low_power` unchanged.
- R9: A break in the fully lowered halt restores `vid_code` with `ratio_code` still at RATIO_MIN for `settle_cycles`+1 cycles. Then it restores `ratio_code` for `settle_cycles`+1 cycles. `pstate` becomes 0 one cycle after `low_power` falls.
- R10: The restored codes are the `op_vid`/`op_ratio` values captured when the halt was entered. Later changes on those inputs do not alter them.
- R11: A break during the entry sequence is held. Entry completes, exit follows at once, and `run_en` rises 4·(`settle_cycles`+1)+2 cycles after the halt edge.
- R12: `run_en` is high exactly when `pstate` is 0, which only happens with no sequence active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| halt_req | input | 1 | Core requests a halt |
| halt_ack | input | 1 | Halt bus cycle has been issued |
| clk_stop_n | input | 1 | Active-low stop-clock request |
| snoop_req | input | 1 | Snoop pending strobe |
| snoop_done | input | 1 | Snoop serviced strobe |
| brk_evt | input | 7 | Break-event lines (bit map in R3) |
| op_vid | input | VID_W | Running voltage code |
| op_ratio | input | RATIO_W | Running core-to-bus ratio |
| settle_cycles | input | CNT_W | Settle count per sequence step |
| pstate | output | 3 | Current state (0..4 as in R2–R5) |
| run_en | output | 1 | Core may execute |
| vid_code | output | VID_W | Voltage code driven to the regulator |
| ratio_code | output | RATIO_W | Ratio code driven to the clock generator |
| low_power | output | 1 | An operating-point sequence or lowered halt is active |

## Verification
The bench targets the ordering of the operating-point steps. A design that swapped them would raise the ratio before the voltage on exit, or lower the voltage first on entry. A break that lands mid-entry is also covered: a design that dropped it would stay halted forever, and one that acted on it at once would run the core at the lowered point. The bench also changes the running codes during a halt, which exposes a restore that uses live inputs instead of captured ones. Held breaks in stop-granted and the priority of stop-clock over a snoop are checked too, since a wrong design there returns to the wrong state.

// File: rtl/stopclk_pkg.sv
package stopclk_pkg;
  localparam int BRK_N = 7;

  typedef enum logic [2:0] {
    ST_NORMAL   = 3'd0,
    ST_HALT     = 3'd1,
    ST_HALT_SNP = 3'd2,
    ST_SGNT     = 3'd3,
    ST_SGNT_SNP = 3'd4
  } pstate_e;

  typedef enum logic [2:0] {
    SQ_IDLE      = 3'd0,
    SQ_ENT_RATIO = 3'd1,
    SQ_ENT_VID   = 3'd2,
    SQ_LOW       = 3'd3,
    SQ_EXT_VID   = 3'd4,
    SQ_EXT_RATIO = 3'd5
  } seq_e;
endpackage

// File: rtl/stopclk_settle_timer.sv
module stopclk_settle_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    if (start) begin
      cnt_d = load_val;
      run_d = 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_d = 1'b0;
      else             cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  assign done = run_q && (cnt_q == '0);

  // settle window counts down one per cycle (R7, R9)
  assert_settle_countdown_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && (cnt_q != '0) && !start) |=> (cnt_q == CNT_W'($past(cnt_q) - 1'b1)));
endmodule

// File: rtl/stopclk_op_seq.sv
module stopclk_op_seq
  import stopclk_pkg::*;
#(
  parameter int VID_W     = 6,
  parameter int RATIO_W   = 5,
  parameter int CNT_W     = 8,
  parameter int RATIO_MIN = 6,
  parameter int VID_LOW   = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enter_req,
  input  logic               exit_req,
  input  logic [VID_W-1:0]   op_vid,
  input  logic [RATIO_W-1:0] op_ratio,
  input  logic [CNT_W-1:0]   settle_cycles,
  output logic [VID_W-1:0]   vid_code,
  output logic [RATIO_W-1:0] ratio_code,
  output logic               seq_idle
);
  localparam logic [RATIO_W-1:0] RMIN = RATIO_W'(RATIO_MIN);
  localparam logic [VID_W-1:0]   VLOW = VID_W'(VID_LOW);

  seq_e               seq_q, seq_d;
  logic [VID_W-1:0]   sv_vid_q;
  logic [RATIO_W-1:0] sv_ratio_q;
  logic               tmr_start, tmr_done, cap_en;

  assign cap_en = enter_req && (seq_q == SQ_IDLE) && (op_ratio > RMIN);

  always_comb begin
    seq_d     = seq_q;
    tmr_start = 1'b0;
    unique case (seq_q)
      SQ_IDLE:      if (cap_en)   begin seq_d = SQ_ENT_RATIO; tmr_start = 1'b1; end
      SQ_ENT_RATIO: if (tmr_done) begin seq_d = SQ_ENT_VID;   tmr_start = 1'b1; end
      SQ_ENT_VID:   if (tmr_done)       seq_d = SQ_LOW;
      SQ_LOW:       if (exit_req) begin seq_d = SQ_EXT_VID;   tmr_start = 1'b1; end
      SQ_EXT_VID:   if (tmr_done) begin seq_d = SQ_EXT_RATIO; tmr_start = 1'b1; end
      SQ_EXT_RATIO: if (tmr_done)       seq_d = SQ_IDLE;
      default:                          seq_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seq_q <= SQ_IDLE;
    else        seq_q <= seq_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sv_vid_q   <= '0;
      sv_ratio_q <= '0;
    end else if (cap_en) begin
      sv_vid_q   <= op_vid;
      sv_ratio_q <= op_ratio;
    end
  end

  stopclk_settle_timer #(.CNT_W(CNT_W)) tmr_i (
    .clk(clk), .rst_n(rst_n), .start(tmr_start),
    .load_val(settle_cycles), .done(tmr_done)
  );

  always_comb begin
    unique case (seq_q)
      SQ_IDLE:                 vid_code = op_vid;
      SQ_ENT_VID, SQ_LOW:      vid_code = VLOW;
      default:                 vid_code = sv_vid_q;
    endcase
    unique case (seq_q)
      SQ_IDLE:                 ratio_code = op_ratio;
      SQ_EXT_RATIO:            ratio_code = sv_ratio_q;
      default:                 ratio_code = RMIN;
    endcase
  end

  assign seq_idle = (seq_q == SQ_IDLE);

  // voltage drops only after the ratio step (R7)
  assert_ratio_before_vid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_q == SQ_ENT_VID) |-> ($past(seq_q) == SQ_ENT_RATIO || $past(seq_q) == SQ_ENT_VID));
  // ratio restores only after the voltage step (R9)
  assert_vid_before_ratio_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_q == SQ_EXT_RATIO && $past(seq_q) != SQ_EXT_RATIO) |-> ($past(seq_q) == SQ_EXT_VID));
endmodule

// File: rtl/stopclk_pwr_ctrl.sv
module stopclk_pwr_ctrl
  import stopclk_pkg::*;
#(
  parameter int VID_W     = 6,
  parameter int RATIO_W   = 5,
  parameter int CNT_W     = 8,
  parameter int RATIO_MIN = 6,
  parameter int VID_LOW   = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               halt_req,
  input  logic               halt_ack,
  input  logic               clk_stop_n,
  input  logic               snoop_req,
  input  logic               snoop_done,
  input  logic [BRK_N-1:0]   brk_evt,
  input  logic [VID_W-1:0]   op_vid,
  input  logic [RATIO_W-1:0] op_ratio,
  input  logic [CNT_W-1:0]   settle_cycles,
  output logic [2:0]         pstate,
  output logic               run_en,
  output logic [VID_W-1:0]   vid_code,
  output logic [RATIO_W-1:0] ratio_code,
  output logic               low_power
);
  logic    rst_meta_q, rst_sync_q;
  pstate_e st_q, st_d;
  logic    from_halt_q, from_halt_d;
  logic    pend_q, pend_d, pend_now;
  logic    enter_req, seq_idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign pend_now  = pend_q || (|brk_evt);
  assign enter_req = (st_q == ST_NORMAL) && clk_stop_n && halt_req && halt_ack;

  always_comb begin
    st_d        = st_q;
    from_halt_d = from_halt_q;
    unique case (st_q)
      ST_NORMAL: begin
        if (!clk_stop_n)    begin st_d = ST_SGNT; from_halt_d = 1'b0; end
        else if (enter_req)       st_d = ST_HALT;
      end
      ST_HALT: begin
        if (!clk_stop_n)    begin st_d = ST_SGNT; from_halt_d = 1'b1; end
        else if (snoop_req)       st_d = ST_HALT_SNP;
        else if (pend_now && seq_idle) st_d = ST_NORMAL;
      end
      ST_HALT_SNP: if (snoop_done) st_d = ST_HALT;
      ST_SGNT: begin
        if (clk_stop_n)     st_d = from_halt_q ? ST_HALT : ST_NORMAL;
        else if (snoop_req) st_d = ST_SGNT_SNP;
      end
      ST_SGNT_SNP: if (snoop_done) st_d = ST_SGNT;
      default: st_d = ST_NORMAL;
    endcase
    pend_d = (st_q == ST_NORMAL) ? 1'b0 : pend_now;
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      st_q        <= ST_NORMAL;
      from_halt_q <= 1'b0;
      pend_q      <= 1'b0;
    end else begin
      st_q        <= st_d;
      from_halt_q <= from_halt_d;
      pend_q      <= pend_d;
    end
  end

  stopclk_op_seq #(
    .VID_W(VID_W), .RATIO_W(RATIO_W), .CNT_W(CNT_W),
    .RATIO_MIN(RATIO_MIN), .VID_LOW(VID_LOW)
  ) seq_i (
    .clk(clk), .rst_n(rst_sync_q),
    .enter_req(enter_req),
    .exit_req(pend_now && (st_q != ST_NORMAL)),
    .op_vid(op_vid), .op_ratio(op_ratio), .settle_cycles(settle_cycles),
    .vid_code(vid_code), .ratio_code(ratio_code), .seq_idle(seq_idle)
  );

  assign pstate    = st_q;
  assign run_en    = (st_q == ST_NORMAL) && seq_idle;
  assign low_power = !seq_idle;

  assert_halt_entry_R2: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (st_q == ST_NORMAL && clk_stop_n && halt_req && halt_ack) |=> (st_q == ST_HALT));
  assert_stop_return_R4: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (st_q == ST_SGNT && clk_stop_n && !from_halt_q) |=> (st_q == ST_NORMAL));
  assert_snoop_return_R5: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (st_q == ST_HALT_SNP && snoop_done) |=> (st_q == ST_HALT));
  assert_stop_holds_R6: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (st_q == ST_SGNT && !clk_stop_n) |=> (st_q == ST_SGNT || st_q == ST_SGNT_SNP));
  assert_normal_idle_R12: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (st_q == ST_NORMAL) |-> seq_idle);
endmodule

// File: tb/stopclk_pwr_ctrl_tb.sv
module stopclk_pwr_ctrl_tb_top;
  localparam int VW = 6, RW = 5, CW = 8, RMIN = 6, VLOW = 20;

  logic clk = 1'b0;
  logic rst_n, halt_req, halt_ack, clk_stop_n, snoop_req, snoop_done;
  logic [6:0] brk_evt;
  logic [VW-1:0] op_vid, vid_code;
  logic [RW-1:0] op_ratio, ratio_code;
  logic [CW-1:0] settle_cycles;
  logic [2:0] pstate;
  logic run_en, low_power;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done_flag = 0;

  always #4 clk = ~clk;

  stopclk_pwr_ctrl #(.VID_W(VW), .RATIO_W(RW), .CNT_W(CW), .RATIO_MIN(RMIN), .VID_LOW(VLOW)) dut_i (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .halt_ack(halt_ack),
    .clk_stop_n(clk_stop_n), .snoop_req(snoop_req), .snoop_done(snoop_done),
    .brk_evt(brk_evt), .op_vid(op_vid), .op_ratio(op_ratio), .settle_cycles(settle_cycles),
    .pstate(pstate), .run_en(run_en), .vid_code(vid_code), .ratio_code(ratio_code),
    .low_power(low_power));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic idle_in();
    halt_req = 0; halt_ack = 0; clk_stop_n = 1;
    snoop_req = 0; snoop_done = 0; brk_evt = '0;
  endtask

  // reference next state for the plain (no operating-point change) graph
  function automatic int ref_next(input int st, input bit fh, input bit pn,
                                  input bit stp_n, input bit hr, input bit ha,
                                  input bit sr, input bit sd);
    case (st)
      0: return !stp_n ? 3 : (hr && ha) ? 1 : 0;
      1: return !stp_n ? 3 : sr ? 2 : pn ? 0 : 1;
      2: return sd ? 1 : 2;
      3: return stp_n ? (fh ? 1 : 0) : sr ? 4 : 3;
      default: return sd ? 3 : 4;
    endcase
  endfunction

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected < 150000 cycles", cyc);
      finish_run();
    end
  end

  initial begin
    int ms, mfh, mpn, nxt, t;
    void'($urandom(32'd4711));
    idle_in();
    op_vid = 6'd40; op_ratio = 5'd12; settle_cycles = 8'd3;
    rst_n = 0;
    tick(3);
    rst_n = 1;
    tick(3);
    // R1 reset state
    chk("R1 pstate", pstate, 0);
    chk("R1 run_en", run_en, 1);
    chk("R1 low_power", low_power, 0);
    chk("R1 vid", vid_code, 40);
    chk("R1 ratio", ratio_code, 12);

    // R2 request without ack does nothing
    halt_req = 1; tick(); chk("R2 no ack", pstate, 0); halt_req = 0;

    // R7 extended entry, R9/R10 exit
    halt_req = 1; halt_ack = 1; tick(); idle_in();
    chk("R2 halt entry", pstate, 1);
    chk("R7 ratio first", ratio_code, RMIN);
    chk("R7 vid held", vid_code, 40);
    chk("R7 low_power", low_power, 1);
    chk("R12 run_en low", run_en, 0);
    tick(3); chk("R7 vid still held", vid_code, 40);
    tick(1); chk("R7 vid lowered", vid_code, VLOW);
    chk("R7 ratio min", ratio_code, RMIN);
    tick(6);
    op_vid = 6'd50; op_ratio = 5'd14;            // R10 late change
    brk_evt = 7'b0001000; tick(); idle_in();
    chk("R9 vid restored", vid_code, 40);
    chk("R9 ratio still min", ratio_code, RMIN);
    tick(3); chk("R9 ratio held", ratio_code, RMIN);
    tick(1); chk("R10 ratio saved", ratio_code, 12);
    chk("R10 vid saved", vid_code, 40);
    chk("R12 not yet running", run_en, 0);
    tick(4); chk("R9 sequence done", low_power, 0);
    chk("R9 still halted", pstate, 1);
    tick(1); chk("R9 normal", pstate, 0);
    chk("R12 run_en", run_en, 1);

    // R11 break during entry
    op_vid = 6'd40; op_ratio = 5'd12;
    halt_req = 1; halt_ack = 1; tick(); idle_in();
    tick(1); brk_evt = 7'b0100000; tick(); idle_in();
    t = 2;
    while (!run_en && t < 60) begin tick(); t++; end
    chk("R11 cycles to run", t, 4 * (3 + 1) + 2);

    // R8 plain halt, R3 break returns at once
    op_ratio = RMIN;
    halt_req = 1; halt_ack = 1; tick(); idle_in();
    chk("R8 halted", pstate, 1);
    chk("R8 vid unchanged", vid_code, 40);
    chk("R8 ratio unchanged", ratio_code, RMIN);
    chk("R8 low_power", low_power, 0);
    brk_evt = 7'b0000001; tick(); idle_in();
    chk("R3 break", pstate, 0);

    // R6 stop-clock beats snoop and break; held break after return
    halt_req = 1; halt_ack = 1; tick(); idle_in();
    clk_stop_n = 0; snoop_req = 1; brk_evt = 7'b1000000; tick();
    snoop_req = 0; brk_evt = '0;
    chk("R6 priority", pstate, 3);
    tick(2); chk("R6 stop holds", pstate, 3);
    clk_stop_n = 1; tick(); chk("R4 back to halt", pstate, 1);
    tick(); chk("R6 held break", pstate, 0);

    // R2-R6, R12 random against reference graph (plain halts)
    ms = 0; mfh = 0; mpn = 0;
    for (int k = 0; k < 4000; k++) begin
      halt_req   = ($urandom % 4) == 0;
      halt_ack   = ($urandom % 2) == 0;
      if (($urandom % 10) == 0) clk_stop_n = ~clk_stop_n;
      snoop_req  = ($urandom % 6) == 0;
      snoop_done = ($urandom % 4) == 0;
      brk_evt    = (($urandom % 12) == 0) ? 7'(1 << ($urandom % 7)) : 7'd0;
      nxt = ref_next(ms, mfh[0], mpn[0] || (|brk_evt), clk_stop_n, halt_req, halt_ack,
                     snoop_req, snoop_done);
      if (ms == 0 && !clk_stop_n) mfh = 0;
      if (ms == 1 && !clk_stop_n) mfh = 1;
      mpn = (ms == 0) ? 0 : (mpn != 0 || (|brk_evt)) ? 1 : 0;
      ms = nxt;
      tick();
      chk("R5 random state", pstate, ms);
      chk("R12 random run_en", run_en, (ms == 0) ? 1 : 0);
    end
    finish_run();
  end
endmodule